// File: doc/BRIEF.md
# Transition-Signalled Modulo-3 Event Counter

This block takes a stream of events on one request wire and answers every event with exactly one event on one of two answer wires. Signalling is two-phase: each change of level is one event, whether the wire goes up or down. The first and second requests of every group of three are answered on the "more" wire. The third is answered on the "last" wire. The count then starts again.

The block is a clocked model of a clockless network. An event merge feeds a first parity toggle. The toggle's odd-numbered events leave directly as "more" answers. Its even-numbered events drive a second toggle. That toggle's odd-numbered events go back into the merge as a feedback event, and its even-numbered events leave as "last" answers. The only state is the two parity bits and the wire levels.

The environment runs a closed handshake: it sends one request and waits for the answer before it sends the next. A request that arrives while an answer is still outstanding is not counted, and it raises an error flag.

Top module: `evt_mod3_counter`

## Requirements
- R1: While and after reset, with no request event since, `more_w`, `last_w` and `proto_err` are all low.
- R2: Every accepted request event produces exactly one answer event, on `more_w` or on `last_w`. An answer event never occurs without an outstanding request, and the two answer wires never change in the same cycle.
- R3: For the n-th accepted request since reset, `more_w` changes level when n mod 3 is 1 or 2, and `last_w` changes level when n mod 3 is 0.
- R4: A rising and a falling change of `req_w` are each one request event, and they are counted alike.
- R5: With `SYNC_STAGES` = 0, an input change is answered at the first clock edge that samples it when n mod 3 is 1 or 0. When n mod 3 is 2 the answer comes one edge later, because it passes through the feedback loop. An answer is never outstanding for more than one cycle after acceptance.
- R6: A request event that arrives while an answer is outstanding sets `proto_err`. With `ERR_STICKY` = 1 the flag stays high until reset. The event is not counted, and it causes no answer event of its own.
- R7: Each toggle routes its odd-numbered input events to its first output and its even-numbered events to its second output. The merge never receives a request and a feedback event in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_w | input | 1 | Request wire; every level change is one event |
| more_w | output | 1 | Answer wire for counts 1 and 2 of each group of three |
| last_w | output | 1 | Answer wire for count 3 of each group of three |
| proto_err | output | 1 | Set by a request that arrives before the previous answer |

## Verification
The in-design assertions assume that `req_w` changes away from the active clock edge and that the environment normally waits for an answer. The merge-collision check holds only because a request arriving early is rejected by the guard, not passed to the merge. The bench changes `req_w` on the falling clock edge and then watches four whole cycles for the answer, so requests never overlap outside the deliberate violation test. That test sends a second change between the acceptance edge and the feedback edge, and it then checks that the group of three resumes as though the extra change had never happened.

// File: rtl/evt_mod3_pkg.sv
package evt_mod3_pkg;

   // Pair of event strobes leaving a parity toggle
   typedef struct packed {
      logic first;   // odd-numbered input events
      logic second;  // even-numbered input events
   } evt_pair_t;

   localparam int MAX_SYNC_STAGES = 4;

endpackage

// File: rtl/evt_in_sync.sv
module evt_in_sync #(
   parameter int STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   output logic lvl_o
);

   generate
      if (STAGES == 0) begin : g_pass
         assign lvl_o = lvl_i;
      end else begin : g_chain
         logic [STAGES-1:0] sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr <= '0;
            else        sr <= {sr[STAGES-2 >= 0 ? STAGES-2 : 0 : 0], lvl_i};
         end
         if (STAGES == 1) begin : g_one
            assign lvl_o = sr[0];
         end else begin : g_many
            assign lvl_o = sr[STAGES-1];
         end
      end
   endgenerate

endmodule

// File: rtl/evt_merge.sv
module evt_merge (
   input  logic clk,
   input  logic rst_n,
   input  logic ev_a_i,
   input  logic ev_b_i,
   output logic ev_o
);

   assign ev_o = ev_a_i | ev_b_i;

   // R7
   no_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ev_a_i && ev_b_i));

endmodule

// File: rtl/evt_toggle.sv
module evt_toggle
   import evt_mod3_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      ev_i,
   output evt_pair_t ev_o
);

   logic par;  // 0: next event is odd-numbered

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    par <= 1'b0;
      else if (ev_i) par <= ~par;
   end

   always_comb begin
      ev_o.first  = ev_i & ~par;
      ev_o.second = ev_i &  par;
   end

   // R7
   par_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_i |=> (par != $past(par)));

   // R7
   par_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ev_i |=> $stable(par));

endmodule

// File: rtl/evt_mod3_counter.sv
module evt_mod3_counter
   import evt_mod3_pkg::*;
#(
   parameter int SYNC_STAGES = 0,
   parameter bit ERR_STICKY  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_w,
   output logic more_w,
   output logic last_w,
   output logic proto_err
);

   generate
      if (SYNC_STAGES < 0 || SYNC_STAGES > MAX_SYNC_STAGES) begin : g_bad_cfg
         $error("evt_mod3_counter: SYNC_STAGES out of range");
      end
   endgenerate

   logic req_s, req_prev, ev_req, acc_req, drop_req;
   logic busy;
   logic fb_lvl, fb_prev, ev_fb, ev_merged;
   logic more_lvl, last_lvl, err_q;
   evt_pair_t stage1_o, stage2_o;

   evt_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .lvl_i(req_w), .lvl_o(req_s));

   // Request event detection and handshake guard
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_prev <= 1'b0;
         fb_prev  <= 1'b0;
      end else begin
         req_prev <= req_s;
         fb_prev  <= fb_lvl;
      end
   end

   assign ev_req   = req_s ^ req_prev;
   assign acc_req  = ev_req & ~busy;
   assign drop_req = ev_req &  busy;
   assign ev_fb    = fb_lvl ^ fb_prev;

   evt_merge u_merge (
      .clk(clk), .rst_n(rst_n),
      .ev_a_i(acc_req), .ev_b_i(ev_fb), .ev_o(ev_merged));

   evt_toggle u_stage1 (
      .clk(clk), .rst_n(rst_n), .ev_i(ev_merged), .ev_o(stage1_o));

   evt_toggle u_stage2 (
      .clk(clk), .rst_n(rst_n), .ev_i(stage1_o.second), .ev_o(stage2_o));

   // Wire levels: each strobe flips its wire
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         more_lvl <= 1'b0;
         last_lvl <= 1'b0;
         fb_lvl   <= 1'b0;
         busy     <= 1'b0;
      end else begin
         more_lvl <= more_lvl ^ stage1_o.first;
         last_lvl <= last_lvl ^ stage2_o.second;
         fb_lvl   <= fb_lvl   ^ stage2_o.first;
         busy     <= (busy | acc_req) & ~(stage1_o.first | stage2_o.second);
      end
   end

   generate
      if (ERR_STICKY) begin : g_err_sticky
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) err_q <= 1'b0;
            else        err_q <= err_q | drop_req;
         end
         // R6
         err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            err_q |=> err_q);
      end else begin : g_err_pulse
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) err_q <= 1'b0;
            else        err_q <= drop_req;
         end
      end
   endgenerate

   assign more_w    = more_lvl;
   assign last_w    = last_lvl;
   assign proto_err = err_q;

   // R1
   reset_idle_chk: assert property (@(posedge clk)
      !rst_n |=> (!more_w && !last_w && !proto_err));

   // R2
   no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !acc_req) |=> ($stable(more_w) && $stable(last_w)));

   // R2
   single_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ($stable(more_w) || $stable(last_w)));

   // R5
   busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !busy);

   // R6
   err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drop_req |=> proto_err);

endmodule

// File: tb/evt_mod3_counter_test.sv
`timescale 1ns/1ps
module evt_mod3_counter_test;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic a_drv = 1'b0;
   logic more_w, last_w, proto_err;

   int checks = 0;
   int errors = 0;
   int ref_n  = 0;

   always #2.5 clk = ~clk;

   evt_mod3_counter uut (
      .clk(clk), .rst_n(rst_n), .req_w(a_drv),
      .more_w(more_w), .last_w(last_w), .proto_err(proto_err));

   // {expect last wire, expect two-cycle latency} for n = 1..9
   localparam logic [1:0] VEC [0:8] = '{
      2'b00, 2'b01, 2'b10, 2'b00, 2'b01, 2'b10, 2'b00, 2'b01, 2'b10 };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Send one request and check which wire answers and after how many cycles
   task automatic send(input bit exp_last, input int exp_lat, input string tag);
      logic q0, p0;
      int got;
      @(negedge clk);
      a_drv = ~a_drv;
      q0 = more_w;
      p0 = last_w;
      got = 0;
      for (int k = 1; k <= 4; k++) begin
         @(negedge clk);
         if (got == 0 && (more_w != q0 || last_w != p0)) begin
            got = k;
            check((last_w != p0) == exp_last, {tag, " wire (R3/R7)"},
                  int'(last_w != p0), int'(exp_last));
         end
      end
      check(got == exp_lat, {tag, " latency (R5)"}, got, exp_lat);
      check(int'(more_w ^ q0) + int'(last_w ^ p0) == 1, {tag, " one answer (R2)"},
            int'(more_w ^ q0) + int'(last_w ^ p0), 1);
   endtask

   task automatic send_ref(input string tag);
      ref_n++;
      send(ref_n % 3 == 0, (ref_n % 3 == 2) ? 2 : 1, tag);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      a_drv = 1'b0;
      repeat (3) @(negedge clk);
      check(!more_w && !last_w && !proto_err, "R1 during reset",
            {more_w, last_w, proto_err}, 0);
      rst_n = 1'b1;
      ref_n = 0;
      @(negedge clk);
      check(!more_w && !last_w && !proto_err, "R1 after reset",
            {more_w, last_w, proto_err}, 0);
   endtask

   initial begin
      do_reset();

      // Table walk; odd entries raise req_w, even entries lower it (R4)
      for (int i = 0; i < 9; i++) begin
         ref_n++;
         send(VEC[i][1], VEC[i][0] ? 2 : 1, (a_drv ? "R4 falling" : "R4 rising"));
      end
      check(proto_err == 1'b0, "R6 no error under handshake", proto_err, 0);

      // Random-length run against the reference count
      begin
         int cnt = 5 + int'($urandom % 20);
         for (int i = 0; i < cnt; i++) send_ref("R3 random");
      end

      // Protocol violation during the feedback cycle
      do_reset();
      send_ref("R3 pre-violation");
      begin
         logic q0, p0;
         q0 = more_w;
         p0 = last_w;
         @(negedge clk);
         a_drv = ~a_drv;          // request n=2, accepted
         @(negedge clk);
         a_drv = ~a_drv;          // early request, to be rejected
         @(negedge clk);
         check(proto_err == 1'b1, "R6 flag set", proto_err, 1);
         repeat (3) @(negedge clk);
         check(proto_err == 1'b1, "R6 flag sticky", proto_err, 1);
         check(more_w != q0, "R6 n=2 answered on more", int'(more_w != q0), 1);
         check(last_w == p0, "R6 no extra answer", int'(last_w != p0), 0);
         ref_n = 2;
      end
      send_ref("R6 rejected event not counted");
      send_ref("R6 sequence resumes");

      do_reset();
      send_ref("R3 after second reset");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(5.0 * 20000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule